// File: doc/BRIEF.md
# Tiled View Address Generator

This unit converts a pixel coordinate into an address inside a tiled container address space. Each request carries an element format (8-bit, 16-bit, 32-bit or page granularity), a view orientation and an X/Y coordinate. From these the unit derives how many coordinate bits the format leaves usable. It mirrors the coordinate when the view asks for it and swaps the roles of X and Y for transposed views. It then packs the coordinate into a linear offset, scales that offset by the format's element alignment and prefixes it with the view and format fields.

Alongside the address the unit reports the row stride that goes with the chosen format and orientation. It also raises a flag when a coordinate falls outside the container, in which case the address is forced to zero. All outputs appear one clock after the request strobe and keep their value while no request is presented.

The container is 14 X bits by 13 Y bits. Page granularity uses a slot of 2^6 by 2^6 elements, so both of its unused-bit counts are 6.

Top module: `tile_view_addr`

## Requirements
- R1: For an in-range request, address bits [28:27] hold the format code: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit, 3 = page.
- R2: For an in-range request, address bits [31:29] hold the 3-bit orientation code exactly as presented.
- R3: If X exceeds (2^(14 - xs)) - 1 or Y exceeds (2^(13 - ys)) - 1, the result address is 0 and the invalid flag is 1. Otherwise the flag is 0. The unused X/Y bit counts (xs, ys) are (0,0) for 8-bit, (0,1) for 16-bit, (1,1) for 32-bit and (6,6) for page.
- R4: Orientation bit 0 replaces X by X XOR its full mask before packing.
- R5: Orientation bit 1 replaces Y by Y XOR its full mask before packing.
- R6: With orientation bit 2 clear, the offset is Y * 2^(14 - xs) + X. With bit 2 set, it is X * 2^(13 - ys) + Y.
- R7: The offset is shifted left by xs + ys and placed in address bits [26:0], so the low xs + ys bits are zero.
- R8: The stride is 2^(13 + xs) when orientation bit 2 is set and 2^(14 + ys) otherwise.
- R9: out_valid is in_valid delayed by one clock. Address, flag and stride update one clock after a request and hold while in_valid is low.
- R10: After reset the outputs are out_valid = 0, address = 0, flag = 0 and stride = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| fmt_i | input | 2 | Element format code |
| orient_i | input | 3 | Orientation: bit0 X invert, bit1 Y invert, bit2 transpose |
| x_i | input | 16 | X coordinate in elements |
| y_i | input | 16 | Y coordinate in elements |
| out_valid | output | 1 | Result valid, one clock after in_valid |
| addr_o | output | 32 | Composed tiled address |
| bad_coord_o | output | 1 | Coordinate out of range |
| stride_o | output | 32 | Row stride in bytes for the format and orientation |

## Verification
Every result (address, invalid flag, stride and out_valid) is due exactly one clock edge after the strobe. The bench drives each request at a falling edge and compares all four outputs at the next falling edge, half a period after the rising edge that registered them. Hold behaviour is checked by dropping the strobe and changing the inputs for one cycle, then confirming at the following falling edge that the registered results did not move.

// File: rtl/tv_pkg.sv
package tv_pkg;

  typedef enum logic [1:0] {
    FMT_B8   = 2'd0,
    FMT_B16  = 2'd1,
    FMT_B32  = 2'd2,
    FMT_PAGE = 2'd3
  } tv_fmt_e;

  localparam int unsigned OR_XINV  = 0;
  localparam int unsigned OR_YINV  = 1;
  localparam int unsigned OR_SWAP  = 2;

  localparam int unsigned SHW = 6;

endpackage

// File: rtl/tv_geom.sv
module tv_geom
  import tv_pkg::*;
#(
  parameter int unsigned CW_BITS = 14,
  parameter int unsigned CH_BITS = 13,
  parameter int unsigned SLOT_XB = 6,
  parameter int unsigned SLOT_YB = 6
) (
  input  logic [1:0]      fmt,
  output logic [SHW-1:0]  xs,
  output logic [SHW-1:0]  ys,
  output logic [SHW-1:0]  xbits,
  output logic [SHW-1:0]  ybits,
  output logic [SHW-1:0]  align,
  output logic [31:0]     xmask,
  output logic [31:0]     ymask
);

  localparam logic [SHW-1:0] CW_L = SHW'(CW_BITS);
  localparam logic [SHW-1:0] CH_L = SHW'(CH_BITS);

  always_comb begin
    unique case (tv_fmt_e'(fmt))
      FMT_B8:   begin xs = '0;               ys = '0;               end
      FMT_B16:  begin xs = '0;               ys = SHW'(1);          end
      FMT_B32:  begin xs = SHW'(1);          ys = SHW'(1);          end
      default:  begin xs = SHW'(SLOT_XB);    ys = SHW'(SLOT_YB);    end
    endcase
  end

  always_comb begin
    xbits = CW_L - xs;
    ybits = CH_L - ys;
    align = xs + ys;
    xmask = (32'd1 << xbits) - 32'd1;
    ymask = (32'd1 << ybits) - 32'd1;
  end

endmodule

// File: rtl/tv_pack.sv
module tv_pack
  import tv_pkg::*;
#(
  parameter int unsigned COORD_W = 16,
  parameter int unsigned OFF_W   = 27
) (
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  input  logic [1:0]         fmt,
  input  logic [2:0]         orient,
  input  logic [SHW-1:0]     xbits,
  input  logic [SHW-1:0]     ybits,
  input  logic [SHW-1:0]     align,
  input  logic [31:0]        xmask,
  input  logic [31:0]        ymask,
  output logic [OFF_W+4:0]   addr,
  output logic               bad
);

  logic [31:0] xw, yw, xm, ym, packed_off, scaled;

  always_comb begin
    xw  = 32'(x);
    yw  = 32'(y);
    bad = (xw > xmask) || (yw > ymask);
    xm  = orient[OR_XINV] ? (xw ^ xmask) : xw;
    ym  = orient[OR_YINV] ? (yw ^ ymask) : yw;
    if (orient[OR_SWAP])
      packed_off = (xm << ybits) + ym;
    else
      packed_off = (ym << xbits) + xm;
    scaled = packed_off << align;
    if (bad)
      addr = '0;
    else
      addr = {orient, fmt, scaled[OFF_W-1:0]};
  end

endmodule

// File: rtl/tv_stride.sv
module tv_stride
  import tv_pkg::*;
#(
  parameter int unsigned CW_BITS = 14,
  parameter int unsigned CH_BITS = 13
) (
  input  logic           swap,
  input  logic [SHW-1:0] xs,
  input  logic [SHW-1:0] ys,
  output logic [31:0]    stride
);

  logic [SHW-1:0] amt;

  always_comb begin
    amt    = swap ? (SHW'(CH_BITS) + xs) : (SHW'(CW_BITS) + ys);
    stride = 32'd1 << amt;
  end

endmodule

// File: rtl/tile_view_addr.sv
module tile_view_addr
  import tv_pkg::*;
#(
  parameter int unsigned COORD_W = 16,
  parameter int unsigned CW_BITS = 14,
  parameter int unsigned CH_BITS = 13,
  parameter int unsigned SLOT_XB = 6,
  parameter int unsigned SLOT_YB = 6,
  localparam int unsigned OFF_W  = CW_BITS + CH_BITS,
  localparam int unsigned ADDR_W = OFF_W + 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [1:0]         fmt_i,
  input  logic [2:0]         orient_i,
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  output logic               out_valid,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               bad_coord_o,
  output logic [31:0]        stride_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  logic [SHW-1:0] xs, ys, xbits, ybits, align;
  logic [31:0]    xmask, ymask;
  logic [ADDR_W-1:0] addr_c;
  logic           bad_c;
  logic [31:0]    stride_c;

  tv_geom #(
    .CW_BITS(CW_BITS), .CH_BITS(CH_BITS),
    .SLOT_XB(SLOT_XB), .SLOT_YB(SLOT_YB)
  ) u_geom (
    .fmt(fmt_i), .xs(xs), .ys(ys), .xbits(xbits), .ybits(ybits),
    .align(align), .xmask(xmask), .ymask(ymask)
  );

  tv_pack #(.COORD_W(COORD_W), .OFF_W(OFF_W)) u_pack (
    .x(x_i), .y(y_i), .fmt(fmt_i), .orient(orient_i),
    .xbits(xbits), .ybits(ybits), .align(align),
    .xmask(xmask), .ymask(ymask), .addr(addr_c), .bad(bad_c)
  );

  tv_stride #(.CW_BITS(CW_BITS), .CH_BITS(CH_BITS)) u_stride (
    .swap(orient_i[OR_SWAP]), .xs(xs), .ys(ys), .stride(stride_c)
  );

  // next-state
  logic              vld_d, bad_d;
  logic [ADDR_W-1:0] addr_d;
  logic [31:0]       stride_d;
  logic              load_en;

  always_comb begin
    load_en  = in_valid;
    vld_d    = in_valid;
    addr_d   = addr_o;
    bad_d    = bad_coord_o;
    stride_d = stride_o;
    if (load_en) begin
      addr_d   = addr_c;
      bad_d    = bad_c;
      stride_d = stride_c;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      out_valid   <= 1'b0;
      addr_o      <= '0;
      bad_coord_o <= 1'b0;
      stride_o    <= '0;
    end else begin
      out_valid   <= vld_d;
      addr_o      <= addr_d;
      bad_coord_o <= bad_d;
      stride_o    <= stride_d;
    end
  end

  // R9
  valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> out_valid);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !in_valid |=> (!out_valid && $stable(addr_o) && $stable(stride_o)));
  // R3
  bad_zero_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && bad_coord_o) |-> (addr_o == '0));
  // R1
  fmt_field_chk: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> (bad_coord_o || (addr_o[OFF_W+1:OFF_W] == $past(fmt_i))));
  // R2
  view_field_chk: assert property (@(posedge clk) disable iff (!rst_q)
    in_valid |=> (bad_coord_o || (addr_o[OFF_W+4:OFF_W+2] == $past(orient_i))));
  // R7
  align_low_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (out_valid && !bad_coord_o && addr_o[OFF_W+1:OFF_W] == 2'd2) |-> (addr_o[1:0] == 2'b00));
  // R8
  stride_onehot_chk: assert property (@(posedge clk) disable iff (!rst_q)
    out_valid |-> ($countones(stride_o) == 1));

endmodule

// File: tb/tile_view_addr_bench.sv
module tile_view_addr_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [1:0]  fmt_i;
  logic [2:0]  orient_i;
  logic [15:0] x_i, y_i;
  logic        out_valid;
  logic [31:0] addr_o;
  logic        bad_coord_o;
  logic [31:0] stride_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  tile_view_addr u_tile_view_addr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .fmt_i(fmt_i),
    .orient_i(orient_i), .x_i(x_i), .y_i(y_i), .out_valid(out_valid),
    .addr_o(addr_o), .bad_coord_o(bad_coord_o), .stride_o(stride_o)
  );

  function automatic int fxs(input logic [1:0] f);
    case (f) 2'd0: return 0; 2'd1: return 0; 2'd2: return 1; default: return 6; endcase
  endfunction
  function automatic int fys(input logic [1:0] f);
    case (f) 2'd0: return 0; 2'd1: return 1; 2'd2: return 1; default: return 6; endcase
  endfunction

  function automatic bit exp_bad(input logic [1:0] f, input int x, input int y);
    longint xm = (64'd1 << (14 - fxs(f))) - 1;
    longint ym = (64'd1 << (13 - fys(f))) - 1;
    return (x > xm) || (y > ym);
  endfunction

  function automatic logic [31:0] exp_addr(input logic [1:0] f, input logic [2:0] o,
                                           input int x, input int y);
    int     xb = 14 - fxs(f);
    int     yb = 13 - fys(f);
    longint xm = (64'd1 << xb) - 1;
    longint ym = (64'd1 << yb) - 1;
    longint xx = x, yy = y, off;
    if (exp_bad(f, x, y)) return 32'd0;
    if (o[0]) xx = xm - xx;
    if (o[1]) yy = ym - yy;
    if (o[2]) off = xx * (64'd1 << yb) + yy;
    else      off = yy * (64'd1 << xb) + xx;
    off = off * (64'd1 << (fxs(f) + fys(f)));
    return {o, f, off[26:0]};
  endfunction

  function automatic logic [31:0] exp_stride(input logic [1:0] f, input logic [2:0] o);
    if (o[2]) return 32'd1 << (13 + fxs(f));
    return 32'd1 << (14 + fys(f));
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] f, input logic [2:0] o, input int x,
                       input int y, input string tag);
    logic [31:0] ea;
    @(negedge clk);
    in_valid = 1'b1; fmt_i = f; orient_i = o; x_i = 16'(x); y_i = 16'(y);
    @(negedge clk);
    in_valid = 1'b0;
    ea = exp_addr(f, o, x, y);
    chk("R9 out_valid", 32'(out_valid), 32'd1);
    chk(tag, addr_o, ea);
    chk("R3 bad flag", 32'(bad_coord_o), 32'(exp_bad(f, x, y)));
    chk("R8 stride", stride_o, exp_stride(f, o));
    if (!exp_bad(f, x, y)) begin
      chk("R1 format field", 32'(addr_o[28:27]), 32'(f));
      chk("R2 view field", 32'(addr_o[31:29]), 32'(o));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] held_a, held_s;
    int unused;
    unused = $urandom(32'h5eed_1234);
    rst_n = 1'b0; in_valid = 1'b0; fmt_i = '0; orient_i = '0; x_i = '0; y_i = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 out_valid", 32'(out_valid), 32'd0);
    chk("R10 addr", addr_o, 32'd0);
    chk("R10 bad", 32'(bad_coord_o), 32'd0);
    chk("R10 stride", stride_o, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // directed corners
    apply(2'd0, 3'd0, 5, 3, "R6 plain pack 8-bit");
    apply(2'd0, 3'd4, 5, 3, "R6 transposed pack 8-bit");
    apply(2'd0, 3'd1, 5, 3, "R4 x invert");
    apply(2'd1, 3'd2, 100, 9, "R5 y invert 16-bit");
    apply(2'd2, 3'd7, 300, 200, "R7 32-bit all flags");
    apply(2'd3, 3'd5, 17, 40, "R7 page transposed");
    for (int f = 0; f < 4; f++) begin
      int mx = (1 << (14 - fxs(2'(f)))) - 1;
      int my = (1 << (13 - fys(2'(f)))) - 1;
      apply(2'(f), 3'd3, mx, my, "R3 max in range");
      apply(2'(f), 3'd0, mx + 1, 0, "R3 x one past mask");
      apply(2'(f), 3'd6, 0, my + 1, "R3 y one past mask");
    end
    for (int o = 0; o < 8; o++)
      apply(2'd1, 3'(o), 1234, 777, "R2 each view");

    // R9 hold: idle cycle with changed inputs
    apply(2'd2, 3'd4, 50, 60, "R6 before hold");
    held_a = addr_o; held_s = stride_o;
    @(negedge clk);
    in_valid = 1'b0; fmt_i = 2'd3; orient_i = 3'd1; x_i = 16'd9; y_i = 16'd9;
    @(negedge clk);
    chk("R9 idle out_valid", 32'(out_valid), 32'd0);
    chk("R9 idle addr hold", addr_o, held_a);
    chk("R9 idle stride hold", stride_o, held_s);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0] f = 2'($urandom);
      logic [2:0] o = 3'($urandom);
      int mx = (1 << (14 - fxs(f)));
      int my = (1 << (13 - fys(f)));
      int x, y;
      if (($urandom % 8) == 0) begin
        x = int'($urandom % 65536); y = int'($urandom % 65536);
      end else begin
        x = int'($urandom % mx); y = int'($urandom % my);
      end
      apply(f, o, x, y, "R6 random address");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule